// File: doc/BRIEF.md
# SPI Burst Transfer Sequencer

This block empties a transmit queue of 32-bit words onto an SPI link as bursts. A burst length is measured in bits, and one burst may span several queue words or end partway through one. Each word leaves as bytes, least-significant byte first, through a built-in byte shifter that runs SPI mode 0 at a fixed clock divider. The bytes that come back on MISO are packed into a receive word by position, and that word is offered to an external receive queue.

The control register fields arrive as plain inputs: the burst-length field, the start-mode bit, the exchange bit, the per-channel master bits, the channel select and the per-channel slave-select control bits. The register file that holds these fields lies outside the block. The sequencer returns one-cycle requests to set or clear the exchange bit, along with transfer-complete and receive-overflow event pulses. The transmit and receive queues also lie outside the block. The sequencer pops the transmit queue through a show-ahead interface and pushes the receive queue with a strobe.

Top module: `spi_burst_seq`

## Requirements
- R1: A burst holds `burst_len_i + 1` bits. This value is loaded into a signed remaining-bits count whenever the count is zero or negative and a word is about to be popped.
- R2: Each word goes out least-significant byte first, and each byte goes out MSB first. The link uses SPI mode 0: `sclk_o` rests low, MOSI holds steady while `sclk_o` is high, MISO is sampled on the rising edge, and one bit takes 4 clocks.
- R3: A popped word sends ceil(min(remaining, 32)/8) bytes, and each byte takes 8 from the remaining count. A 20-bit burst therefore sends 3 bytes.
- R4: Received bytes fill the receive word by position, with the first byte in bits 7:0 and unsent byte lanes at zero. The word is pushed with `rx_push_o` once its last byte completes.
- R5: If `rx_full_i` is high when a word completes, the word is dropped (no `rx_push_o`) and `ro_o` pulses once.
- R6: There are three start triggers. With start-mode set, a `tx_wr_i` strobe starts a run. A rise of start-mode while the transmit queue is non-empty starts a run. With start-mode clear, a rise of the exchange bit starts a run. All three are ignored unless the selected channel's bit in `chan_master_i` is 1.
- R7: `busy_o` is high from the accepted trigger until the sequencer stops. A trigger that arrives while busy starts no second run.
- R8: Multi-burst mode holds when the selected channel is master, start-mode is clear, and `ss_ctl_i[chan_sel_i]` is 1. In this mode `xch_set_o` pulses each time a new burst length is loaded.
- R9: When the remaining count reaches zero or below at the end of a word and multi-burst mode is off, `tc_o` pulses and the run stops, even if words remain in the queue.
- R10: When the sequencer finds the transmit queue empty, or stops on R9 with the queue empty, `tc_o` and `xch_clr_o` pulse together.
- R11: `tx_pop_o` is asserted only while `tx_empty_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| burst_len_i | input | BLW | Burst-length field (bits minus one) |
| start_mode_i | input | 1 | Start-mode bit |
| xch_i | input | 1 | Current exchange bit |
| chan_master_i | input | CH_N | Per-channel master-mode bits |
| chan_sel_i | input | CHW | Selected channel |
| ss_ctl_i | input | CH_N | Per-channel slave-select control bits |
| tx_wr_i | input | 1 | Strobe: software wrote a TX word |
| tx_empty_i | input | 1 | TX queue empty |
| tx_data_i | input | DW | TX queue head word (show-ahead) |
| tx_pop_o | output | 1 | Pop TX queue head |
| rx_full_i | input | 1 | RX queue full |
| rx_push_o | output | 1 | Push assembled RX word |
| rx_data_o | output | DW | Assembled RX word |
| xch_set_o | output | 1 | Request to set the exchange bit |
| xch_clr_o | output | 1 | Request to clear the exchange bit |
| tc_o | output | 1 | Transfer-complete event |
| ro_o | output | 1 | Receive-overflow event |
| busy_o | output | 1 | Run in progress |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
Two events can fall in the same cycle: the completion of a word's last byte, and the decision on whether the burst is over. So one clock can carry both the push or overflow of a receive word and the `tc_o`/`xch_clr_o` pair. The bench provokes this with a short non-multi burst and a queue that still holds a word, and again with the queue already drained. It judges every event counter, plus the word left in the queue, against a software model of the burst arithmetic. Overflow is forced by holding `rx_full_i` high during a one-byte burst, so `ro_o` and `tc_o` coincide while no push occurs.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_NEXT,
    ST_BYTE,
    ST_WAIT
  } seq_st_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [PW-1:0] ph_q;
  logic [2:0]    bc_q;
  logic [7:0]    tsh_q, rsh_q;
  logic          act_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      bc_q  <= '0;
      tsh_q <= '0;
      rsh_q <= '0;
      act_q <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      dn_q <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q <= 1'b1;
          ph_q  <= '0;
          bc_q  <= '0;
          tsh_q <= tx_byte_i;
        end
      end else begin
        ph_q <= (ph_q == PW'(DIV-1)) ? '0 : ph_q + 1'b1;
        // rising sclk edge follows this cycle
        if (ph_q == PW'(HALF-1)) rsh_q <= {rsh_q[6:0], miso_i};
        if (ph_q == PW'(DIV-1)) begin
          tsh_q <= {tsh_q[6:0], 1'b0};
          if (bc_q == 3'd7) begin
            act_q <= 1'b0;
            dn_q  <= 1'b1;
          end else begin
            bc_q <= bc_q + 3'd1;
          end
        end
      end
    end
  end

  assign sclk_o    = act_q && (ph_q >= PW'(HALF));
  assign mosi_o    = tsh_q[7];
  assign done_o    = dn_q;
  assign rx_byte_o = rsh_q;
endmodule

// File: rtl/spi_start_trig.sv
module spi_start_trig #(
  parameter int CH_N = 4,
  parameter int CHW  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_mode_i,
  input  logic            xch_i,
  input  logic            tx_wr_i,
  input  logic            tx_empty_i,
  input  logic [CH_N-1:0] chan_master_i,
  input  logic [CHW-1:0]  chan_sel_i,
  input  logic [CH_N-1:0] ss_ctl_i,
  input  logic            busy_i,
  output logic            start_o,
  output logic            multi_o
);
  logic sm_q, xch_q, master;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sm_q  <= 1'b0;
      xch_q <= 1'b0;
    end else begin
      sm_q  <= start_mode_i;
      xch_q <= xch_i;
    end
  end

  assign master  = chan_master_i[chan_sel_i];
  assign multi_o = master && !start_mode_i && ss_ctl_i[chan_sel_i];
  assign start_o = master && !busy_i &&
                   ((start_mode_i && tx_wr_i) ||
                    (start_mode_i && !sm_q && !tx_empty_i) ||
                    (!start_mode_i && xch_i && !xch_q));
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_seq_pkg::*;
#(
  parameter int BLW  = 12,
  parameter int DW   = 32,
  parameter int CH_N = 4,
  parameter int CHW  = 2,
  parameter int DIV  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [BLW-1:0]  burst_len_i,
  input  logic            start_mode_i,
  input  logic            xch_i,
  input  logic [CH_N-1:0] chan_master_i,
  input  logic [CHW-1:0]  chan_sel_i,
  input  logic [CH_N-1:0] ss_ctl_i,
  input  logic            tx_wr_i,
  input  logic            tx_empty_i,
  input  logic [DW-1:0]   tx_data_i,
  output logic            tx_pop_o,
  input  logic            rx_full_i,
  output logic            rx_push_o,
  output logic [DW-1:0]   rx_data_o,
  output logic            xch_set_o,
  output logic            xch_clr_o,
  output logic            tc_o,
  output logic            ro_o,
  output logic            busy_o,
  output logic            sclk_o,
  output logic            mosi_o,
  input  logic            miso_i
);
  localparam int NBY = DW / 8;
  localparam int BIW = (NBY > 2) ? $clog2(NBY) : 1;
  localparam int RW  = BLW + 2;

  seq_st_e              st_q;
  logic signed [RW-1:0] rem_q, len, eff, rem_dec;
  logic [DW-1:0]        tx_w_q, rx_w_q, rx_nx;
  logic [BIW-1:0]       bidx_q, last_q, last_nx;
  logic                 start, multi, sh_start, sh_done, word_end, stop;
  logic [7:0]           sh_rx;

  spi_start_trig #(.CH_N(CH_N), .CHW(CHW)) u_trig (
    .clk_i, .rst_ni, .start_mode_i, .xch_i, .tx_wr_i, .tx_empty_i,
    .chan_master_i, .chan_sel_i, .ss_ctl_i,
    .busy_i  (busy_o),
    .start_o (start),
    .multi_o (multi)
  );

  spi_byte_shifter #(.DIV(DIV)) u_shift (
    .clk_i, .rst_ni,
    .start_i   (sh_start),
    .tx_byte_i (tx_w_q[7:0]),
    .miso_i,
    .sclk_o,
    .mosi_o,
    .done_o    (sh_done),
    .rx_byte_o (sh_rx)
  );

  assign len     = RW'({2'b00, burst_len_i}) + RW'(1);
  assign eff     = (rem_q <= 0) ? len : rem_q;
  assign rem_dec = rem_q - RW'(8);

  // last byte lane used by this word: ceil(min(eff, DW)/8) - 1
  always_comb begin
    last_nx = '0;
    for (int k = 1; k < NBY; k++)
      if (eff > RW'(8*k)) last_nx = BIW'(k);
  end

  always_comb begin
    rx_nx = rx_w_q;
    for (int k = 0; k < NBY; k++)
      if (bidx_q == BIW'(k)) rx_nx[8*k +: 8] = sh_rx;
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign sh_start  = (st_q == ST_BYTE);
  assign word_end  = (st_q == ST_WAIT) && sh_done && (bidx_q == last_q);
  assign stop      = word_end && (rem_dec <= 0) && !multi;
  assign tx_pop_o  = (st_q == ST_NEXT) && !tx_empty_i;
  assign xch_set_o = tx_pop_o && (rem_q <= 0) && multi;
  assign rx_push_o = word_end && !rx_full_i;
  assign ro_o      = word_end && rx_full_i;
  assign rx_data_o = rx_nx;
  assign tc_o      = ((st_q == ST_NEXT) && tx_empty_i) || stop;
  assign xch_clr_o = tc_o && tx_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      tx_w_q <= '0;
      rx_w_q <= '0;
      bidx_q <= '0;
      last_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) st_q <= ST_NEXT;
        ST_NEXT: begin
          if (tx_empty_i) begin
            st_q <= ST_IDLE;
          end else begin
            if (rem_q <= 0) rem_q <= len;
            tx_w_q <= tx_data_i;
            rx_w_q <= '0;
            bidx_q <= '0;
            last_q <= last_nx;
            st_q   <= ST_BYTE;
          end
        end
        ST_BYTE: st_q <= ST_WAIT;
        ST_WAIT: if (sh_done) begin
          rem_q  <= rem_dec;
          tx_w_q <= tx_w_q >> 8;
          rx_w_q <= rx_nx;
          bidx_q <= bidx_q + 1'b1;
          if (!word_end)  st_q <= ST_BYTE;
          else if (stop)  st_q <= ST_IDLE;
          else            st_q <= ST_NEXT;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_seq_chk.sv
module spi_burst_seq_chk #(
  parameter int CH_N = 4,
  parameter int CHW  = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_mode_i,
  input logic [CH_N-1:0] chan_master_i,
  input logic [CHW-1:0]  chan_sel_i,
  input logic [CH_N-1:0] ss_ctl_i,
  input logic            tx_empty_i,
  input logic            tx_pop_o,
  input logic            rx_full_i,
  input logic            rx_push_o,
  input logic            ro_o,
  input logic            tc_o,
  input logic            xch_set_o,
  input logic            xch_clr_o,
  input logic            busy_o,
  input logic            sclk_o,
  input logic            mosi_o
);
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o && !tx_pop_o && !rx_push_o); // R7
  AST_PUSH_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !rx_full_i && !ro_o); // R5
  AST_OVF_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_o |-> rx_full_i); // R5
  AST_TC_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !busy_o); // R9
  AST_CLR_WITH_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xch_clr_o |-> tc_o && tx_empty_i); // R10
  AST_MOSI_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o)); // R2
  AST_SET_MULTI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xch_set_o |-> !start_mode_i && ss_ctl_i[chan_sel_i] && chan_master_i[chan_sel_i]); // R8
endmodule

bind spi_burst_seq spi_burst_seq_chk #(.CH_N(CH_N), .CHW(CHW)) u_chk (.*);

// File: tb/spi_burst_seq_test.sv
module spi_burst_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] burst_len = '0;
  logic        start_mode = 1'b0, xch = 1'b0, tx_wr = 1'b0, rx_full = 1'b0;
  logic [3:0]  chan_master = 4'b0001, ss_ctl = 4'b0000;
  logic [1:0]  chan_sel = '0;
  logic        tx_empty = 1'b1;
  logic [31:0] tx_data = '0;
  logic        tx_pop, rx_push, xch_set, xch_clr, tc, ro, busy, sclk, mosi;
  logic        miso = 1'b0;
  logic [31:0] rx_data;

  int n_chk = 0, n_fail = 0;
  int tc_cnt = 0, ro_cnt = 0, set_cnt = 0, clr_cnt = 0, start_cnt = 0;
  int m_tc = 0, m_ro = 0, m_set = 0, m_clr = 0;
  int m_rem = 0, mk = 0, kb = 0, sb = 0, mbit = 0;
  logic [7:0]  mcap = '0;
  logic        pop_q = 1'b0, sclk_p = 1'b0, busy_p = 1'b0;
  logic [31:0] tx_q[$], mq[$], exp_rx[$];
  logic [7:0]  exp_mosi[$];

  always #5 clk = ~clk;

  spi_burst_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .burst_len_i(burst_len), .start_mode_i(start_mode),
    .xch_i(xch), .chan_master_i(chan_master), .chan_sel_i(chan_sel), .ss_ctl_i(ss_ctl),
    .tx_wr_i(tx_wr), .tx_empty_i(tx_empty), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_data), .xch_set_o(xch_set),
    .xch_clr_o(xch_clr), .tc_o(tc), .ro_o(ro), .busy_o(busy), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso)
  );

  function automatic logic [7:0] resp(int k);
    return 8'h3C ^ 8'(k * 29);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void refresh();
    tx_empty = (tx_q.size() == 0);
    tx_data  = (tx_q.size() != 0) ? tx_q[0] : 32'h0;
  endfunction

  always @(posedge clk) pop_q <= tx_pop;

  // TX queue, slave model and scoreboard monitor
  always @(negedge clk) begin
    if (pop_q) begin
      void'(tx_q.pop_front());
      refresh();
    end
    if (sclk && !sclk_p) begin
      mcap = {mcap[6:0], mosi};
      mbit++;
      if (mbit == 8) begin
        mbit = 0;
        if (exp_mosi.size() == 0) chk("R2 unexpected MOSI byte", {24'h0, mcap}, 32'hFFFF_FFFF);
        else chk("R2 MOSI byte", {24'h0, mcap}, {24'h0, exp_mosi.pop_front()});
      end
    end
    if (!sclk && sclk_p) begin
      sb++;
      if (sb == 8) begin sb = 0; kb++; end
    end
    miso = resp(kb)[7 - sb];
    if (rx_push) begin
      if (exp_rx.size() == 0) chk("R4 unexpected RX push", rx_data, 32'hFFFF_FFFF);
      else chk("R4 RX word", rx_data, exp_rx.pop_front());
    end
    if (tc) tc_cnt++;
    if (ro) ro_cnt++;
    if (xch_set) set_cnt++;
    if (xch_clr) clr_cnt++;
    if (busy && !busy_p) start_cnt++;
    sclk_p = sclk;
    busy_p = busy;
  end

  // requirement model of one run
  task automatic model_run(int bits, bit multi, bit full);
    forever begin
      logic [31:0] w, rx;
      int tb, idx;
      if (mq.size() == 0) begin m_tc++; m_clr++; break; end
      if (m_rem <= 0) begin m_rem = bits; if (multi) m_set++; end
      w = mq.pop_front();
      tb = (m_rem > 32) ? 32 : m_rem;
      rx = '0; idx = 0;
      while (tb > 0) begin
        exp_mosi.push_back(w[7:0]);
        rx[8*idx +: 8] = resp(mk);
        mk++; w = w >> 8; tb -= 8; m_rem -= 8; idx++;
      end
      if (full) m_ro++; else exp_rx.push_back(rx);
      if (m_rem <= 0 && !multi) begin
        m_tc++;
        if (mq.size() == 0) m_clr++;
        break;
      end
    end
  endtask

  task automatic push_tx(logic [31:0] w);
    @(negedge clk);
    tx_q.push_back(w);
    mq.push_back(w);
    refresh();
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_counts(string req);
    chk({req, " tc count"}, tc_cnt, m_tc);
    chk({req, " ro count"}, ro_cnt, m_ro);
    chk({req, " xch_set count"}, set_cnt, m_set);
    chk({req, " xch_clr count"}, clr_cnt, m_clr);
    chk({req, " MOSI all sent"}, exp_mosi.size(), 0);
    chk({req, " RX all pushed"}, exp_rx.size(), 0);
  endtask

  task automatic rise_xch();
    @(negedge clk); xch = 1'b0;
    repeat (2) @(negedge clk); xch = 1'b1;
  endtask

  initial begin
    int s0;
    refresh();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R7 busy after reset", busy, 0);
    chk("R2 sclk idle low", sclk, 0);
    chk("R11 no pop after reset", tx_pop, 0);
    chk("R10 no tc after reset", tc, 0);

    // T1: start-mode write trigger, full 32-bit burst, LSB byte first
    burst_len = 12'd31;
    start_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 start-mode rise with empty queue stays idle", busy, 0);
    push_tx(32'h1122_3344);
    model_run(32, 0, 0);
    wait_idle();
    chk_counts("R10 R2 R4 T1");

    // T2: 12-bit bursts, stop with a word left, then restart
    start_mode = 1'b0;
    burst_len = 12'd11;
    push_tx(32'hA1B2_C3D4);
    push_tx(32'h0506_0708);
    repeat (3) @(negedge clk);
    chk("R6 TX write without start-mode does not start", busy, 0);
    rise_xch();
    model_run(12, 0, 0);
    wait_idle();
    chk("R9 word left in queue", tx_q.size(), 1);
    chk_counts("R9 R1 R3 T2a");
    rise_xch();
    model_run(12, 0, 0);
    wait_idle();
    chk("R10 queue drained", tx_q.size(), 0);
    chk_counts("R10 R1 T2b");
    xch = 1'b0;

    // T3: multi-burst mode across three words
    ss_ctl = 4'b0001;
    burst_len = 12'd15;
    push_tx(32'hDEAD_0001);
    push_tx(32'hBEEF_0002);
    push_tx(32'hCAFE_0003);
    rise_xch();
    model_run(16, 1, 0);
    wait_idle();
    chk_counts("R8 T3");
    xch = 1'b0;
    ss_ctl = 4'b0000;

    // T4: 64-bit burst spanning two words, write during busy ignored as trigger
    start_mode = 1'b1;
    burst_len = 12'd63;
    s0 = start_cnt;
    push_tx(32'h0F1E_2D3C);
    repeat (5) @(negedge clk);
    push_tx(32'h4B5A_6978);
    model_run(64, 0, 0);
    wait_idle();
    chk("R7 single run for two writes", start_cnt - s0, 1);
    chk_counts("R1 R3 R7 T4");

    // T5: 20-bit burst, three bytes, top lane zero
    burst_len = 12'd19;
    push_tx(32'hAABB_CCDD);
    model_run(20, 0, 0);
    wait_idle();
    chk_counts("R3 R4 T5");

    // T6: overflow
    rx_full = 1'b1;
    burst_len = 12'd7;
    push_tx(32'h0000_0055);
    model_run(8, 0, 1);
    wait_idle();
    chk_counts("R5 T6");
    rx_full = 1'b0;

    // T7: start-mode rise with a filled queue
    start_mode = 1'b0;
    push_tx(32'h0000_0099);
    repeat (3) @(negedge clk);
    chk("R6 idle before start-mode rise", busy, 0);
    start_mode = 1'b1;
    model_run(8, 0, 0);
    wait_idle();
    chk_counts("R6 T7");

    // T8: selected channel not master ignores trigger; then master on channel 2
    start_mode = 1'b0;
    chan_master = 4'b1011;
    chan_sel = 2'd2;
    push_tx(32'h0000_00C3);
    s0 = start_cnt;
    rise_xch();
    repeat (40) @(negedge clk);
    chk("R6 slave channel no start", start_cnt - s0, 0);
    chk("R6 slave channel queue untouched", tx_q.size(), 1);
    chk("R6 slave channel no MOSI bytes", exp_mosi.size(), 0);
    chan_master = 4'b0100;
    rise_xch();
    model_run(8, 0, 0);
    wait_idle();
    chk_counts("R6 T8");
    chk("R10 queue empty at end", tx_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule